// File: doc/BRIEF.md
# Synthetic ADC Register Block

This block is a word-wide register file that takes the place of an analog-to-digital converter in a system where no real analog front end exists. Software sees the usual set of converter registers. These are a status word, two control words, two sample-time words, a high and a low threshold, three regular sequence words and one injected sequence word, four injected offset/data pairs, and a regular data register. Software can program, read back and clear them as it would on a real converter.

No real input is sampled. A read of the regular data register yields a pseudo-sample when the converter is on and a software start is pending. The pseudo-sample comes from an internal counter that steps by 7 on each conversion. It is cut to the selected resolution and may be left-aligned. The read also consumes the pending start. A read of an injected data register returns the stored data less the matching offset. The interrupt output is held inactive. A separate error output flags any access to an offset that maps to no register.

The port is a plain single-cycle register bus. A write takes effect on the clock edge where the write enable is high. A read returns its data on the following cycle. No back-pressure exists: every access completes in one cycle.

Top module: `synth_adc_regs`

## Requirements
- R1: After reset every register reads zero, except the high threshold at offset 0x24, which reads 0x00000FFF. Register offsets are: status 0x00, control-1 0x04, control-2 0x08, sample-time 0x0C/0x10, injected offsets 0x14..0x20, high threshold 0x24, low threshold 0x28, regular sequence 0x2C..0x34, injected sequence 0x38, injected data 0x3C..0x48, regular data 0x4C.
- R2: Read data appears on bus_rdata in the cycle after bus_re is sampled high, and holds its value in every cycle with no read.
- R3: A write to status (0x00) leaves status equal to its old value ANDed with bits [5:0] of the write data, so no bit can ever be set by software.
- R4: Control-2 (0x08) stores all 32 written bits, and reads return them with bits [31:28] forced to zero.
- R5: Control-1, both sample-time words, both thresholds, the three regular sequence words, the injected sequence word and the four injected data words store the full 32-bit write value and read it back unchanged.
- R6: A write to injected offset n (0x14 + 4n) keeps only bits [11:0], and reads return those bits zero-extended.
- R7: A read of injected data n (0x3C + 4n) returns stored data n minus stored offset n, modulo 2^32.
- R8: A read of regular data (0x4C) produces a sample only when control-2 bit 0 (converter on) and bit 30 (software start) are both set; that read clears bit 30. Otherwise it returns zero and changes no state.
- R9: On a produced sample, the internal counter becomes (counter + 7) masked by control-1 bits [25:24]: 0 keeps 12 bits, 1 keeps 10, 2 keeps 8, 3 keeps 6. The counter starts at 0 after reset.
- R10: With control-2 bit 11 set, the returned sample is (counter << 1) & 0xFFF0; otherwise it is the counter itself.
- R11: An access to an offset that is not a multiple of 4 or is above 0x4C reads zero and is ignored on write. For such an access, bus_err is high in the following cycle only. Writes to 0x4C are ignored without error.
- R12: irq is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle flag for an access to an unmapped offset |
| irq | output | 1 | Interrupt, held low |

## Verification
A read result and the error flag for an access are both due exactly one cycle after the access is presented. The bench drives each access on a falling edge and checks bus_rdata and bus_err on the next falling edge, after one rising edge. Write effects and read side effects, such as a consumed software start or a stepped counter, are due at that same rising edge. The bench therefore observes them through the next read. A reference model in the bench applies each read before the write of the same cycle, which matches registered read-before-write timing.

// File: rtl/adcstub_pkg.sv
package adcstub_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned STAT_W   = 6;
  localparam int unsigned OFS_W    = 12;
  localparam int unsigned SAMP_W   = 12;
  localparam int unsigned N_INJ    = 4;
  localparam int unsigned N_SMP    = 2;
  localparam int unsigned N_SEQ    = 3;
  localparam int unsigned REG_ID_W = 5;

  // Control-2 bit positions and the control-1 resolution field position
  localparam int unsigned ON_BIT    = 0;
  localparam int unsigned ALIGN_BIT = 11;
  localparam int unsigned START_BIT = 30;
  localparam int unsigned RES_LSB   = 24;
  localparam logic [WORD_W-1:0] CTL2_RD_MASK = 32'h0FFF_FFFF;
  localparam logic [WORD_W-1:0] HI_RESET     = 32'h0000_0FFF;

  // Enum order equals word index (offset / 4)
  typedef enum logic [REG_ID_W-1:0] {
    RI_STAT, RI_CTL1, RI_CTL2, RI_SMP0, RI_SMP1,
    RI_IOFS0, RI_IOFS1, RI_IOFS2, RI_IOFS3,
    RI_HI, RI_LO, RI_SEQ0, RI_SEQ1, RI_SEQ2, RI_ISEQ,
    RI_IDAT0, RI_IDAT1, RI_IDAT2, RI_IDAT3,
    RI_DATA, RI_NONE
  } reg_id_t;

  localparam int unsigned LAST_IDX = 19;
endpackage

// File: rtl/adc_addr_decode.sv
module adc_addr_decode
  import adcstub_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_id_t           id_o,
  output logic              hit_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;

  always_comb begin
    widx  = addr_i[ADDR_W-1:2];
    hit_o = (addr_i[1:0] == 2'b00) && (widx <= IDX_W'(LAST_IDX));
    id_o  = hit_o ? reg_id_t'(widx[REG_ID_W-1:0]) : RI_NONE;
  end
endmodule

// File: rtl/adc_sample_fmt.sv
module adc_sample_fmt
  import adcstub_pkg::*;
(
  input  logic [SAMP_W-1:0] cur_i,
  input  logic [1:0]        res_i,
  input  logic              align_i,
  output logic [SAMP_W-1:0] nxt_o,
  output logic [WORD_W-1:0] fmt_o
);
  localparam logic [SAMP_W-1:0] STEP = SAMP_W'(7);

  logic [SAMP_W-1:0] keep_mask;
  logic [SAMP_W-1:0] stepped;

  always_comb begin
    keep_mask = {SAMP_W{1'b1}} >> {res_i, 1'b0};
    stepped   = cur_i + STEP;
    nxt_o     = stepped & keep_mask;
    // left alignment: one-bit shift, low nibble dropped
    if (align_i) fmt_o = WORD_W'({nxt_o[SAMP_W-1:3], 4'b0000});
    else         fmt_o = WORD_W'(nxt_o);
  end
endmodule

// File: rtl/adc_inj_pair.sv
module adc_inj_pair
  import adcstub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ofs_we_i,
  input  logic              dat_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [WORD_W-1:0] diff_o
);
  logic [OFS_W-1:0]  ofs_q;
  logic [WORD_W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q <= '0;
      dat_q <= '0;
    end else begin
      if (ofs_we_i) ofs_q <= wdata_i[OFS_W-1:0];
      if (dat_we_i) dat_q <= wdata_i;
    end
  end

  assign ofs_o  = ofs_q;
  assign diff_o = dat_q - WORD_W'(ofs_q);
endmodule

// File: rtl/synth_adc_regs.sv
module synth_adc_regs
  import adcstub_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              irq
);
  reg_id_t acc_id;
  logic    acc_hit;

  logic [STAT_W-1:0] stat_q;
  logic [WORD_W-1:0] ctl1_q, ctl2_q, hi_q, lo_q, iseq_q;
  logic [WORD_W-1:0] smp_q [N_SMP];
  logic [WORD_W-1:0] seq_q [N_SEQ];
  logic [SAMP_W-1:0] samp_q, samp_nxt;
  logic [WORD_W-1:0] samp_fmt;
  logic [OFS_W-1:0]  inj_ofs  [N_INJ];
  logic [WORD_W-1:0] inj_diff [N_INJ];
  logic [WORD_W-1:0] rd_val;
  logic              go, dr_rd, fire;

  adc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr),
    .id_o   (acc_id),
    .hit_o  (acc_hit)
  );

  adc_sample_fmt u_fmt (
    .cur_i   (samp_q),
    .res_i   (ctl1_q[RES_LSB+1:RES_LSB]),
    .align_i (ctl2_q[ALIGN_BIT]),
    .nxt_o   (samp_nxt),
    .fmt_o   (samp_fmt)
  );

  for (genvar i = 0; i < N_INJ; i++) begin : g_inj
    adc_inj_pair u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .ofs_we_i (bus_we && (acc_id == reg_id_t'(int'(RI_IOFS0) + i))),
      .dat_we_i (bus_we && (acc_id == reg_id_t'(int'(RI_IDAT0) + i))),
      .wdata_i  (bus_wdata),
      .ofs_o    (inj_ofs[i]),
      .diff_o   (inj_diff[i])
    );
  end

  assign go    = ctl2_q[ON_BIT] & ctl2_q[START_BIT];
  assign dr_rd = bus_re && (acc_id == RI_DATA);
  assign fire  = dr_rd && go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ctl1_q <= '0;
      ctl2_q <= '0;
      hi_q   <= HI_RESET;
      lo_q   <= '0;
      iseq_q <= '0;
      samp_q <= '0;
      for (int i = 0; i < int'(N_SMP); i++) smp_q[i] <= '0;
      for (int i = 0; i < int'(N_SEQ); i++) seq_q[i] <= '0;
    end else begin
      if (bus_we) begin
        case (acc_id)
          RI_STAT: stat_q   <= stat_q & bus_wdata[STAT_W-1:0];
          RI_CTL1: ctl1_q   <= bus_wdata;
          RI_CTL2: ctl2_q   <= bus_wdata;
          RI_SMP0: smp_q[0] <= bus_wdata;
          RI_SMP1: smp_q[1] <= bus_wdata;
          RI_HI:   hi_q     <= bus_wdata;
          RI_LO:   lo_q     <= bus_wdata;
          RI_SEQ0: seq_q[0] <= bus_wdata;
          RI_SEQ1: seq_q[1] <= bus_wdata;
          RI_SEQ2: seq_q[2] <= bus_wdata;
          RI_ISEQ: iseq_q   <= bus_wdata;
          default: ;
        endcase
      end
      if (fire) begin
        ctl2_q[START_BIT] <= 1'b0;
        samp_q            <= samp_nxt;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (acc_id)
      RI_STAT: rd_val = WORD_W'(stat_q);
      RI_CTL1: rd_val = ctl1_q;
      RI_CTL2: rd_val = ctl2_q & CTL2_RD_MASK;
      RI_SMP0: rd_val = smp_q[0];
      RI_SMP1: rd_val = smp_q[1];
      RI_HI:   rd_val = hi_q;
      RI_LO:   rd_val = lo_q;
      RI_SEQ0: rd_val = seq_q[0];
      RI_SEQ1: rd_val = seq_q[1];
      RI_SEQ2: rd_val = seq_q[2];
      RI_ISEQ: rd_val = iseq_q;
      RI_DATA: rd_val = go ? samp_fmt : '0;
      default: rd_val = '0;
    endcase
    for (int i = 0; i < int'(N_INJ); i++) begin
      if (acc_id == reg_id_t'(int'(RI_IOFS0) + i)) rd_val = WORD_W'(inj_ofs[i]);
      if (acc_id == reg_id_t'(int'(RI_IDAT0) + i)) rd_val = inj_diff[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= rd_val;
      bus_err <= (bus_re || bus_we) && !acc_hit;
    end
  end

  assign irq = 1'b0;

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  // R3
  stat_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q)) == '0));

  // R8
  start_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !ctl2_q[START_BIT]);

  // R8
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rd && !go) |=> ($stable(samp_q) && (bus_rdata == '0)));

  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_re || bus_we));
endmodule

// File: tb/synth_adc_regs_test.sv
module synth_adc_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [31:0] bus_rdata;
  logic        bus_err, irq;

  always #5 clk = ~clk;

  synth_adc_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] m [20];
  logic [11:0] m_samp;
  logic [31:0] last_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit undef(input logic [7:0] a);
    return (a[1:0] != 2'b00) || (a > 8'h4C);
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    int idx;
    if (undef(a)) return "R11";
    idx = int'(a >> 2);
    if (idx == 0) return "R3";
    if (idx == 2) return "R4";
    if (idx >= 5 && idx <= 8) return "R6";
    if (idx >= 15 && idx <= 18) return "R7";
    if (idx == 19) return "R9";
    return "R5";
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    int idx;
    logic [11:0] msk;
    if (undef(a)) return 32'h0;
    idx = int'(a >> 2);
    case (idx)
      2: return m[2] & 32'h0FFF_FFFF;
      15, 16, 17, 18: return m[idx] - m[idx-10];
      19: begin
        if (m[2][0] && m[2][30]) begin
          m[2][30] = 1'b0;
          msk = 12'hFFF >> (2 * int'(m[1][25:24]));
          m_samp = (m_samp + 12'd7) & msk;
          if (m[2][11]) return ({20'h0, m_samp} << 1) & 32'hFFF0;
          return {20'h0, m_samp};
        end
        return 32'h0;
      end
      default: return m[idx];
    endcase
  endfunction

  task automatic exp_wr(input logic [7:0] a, input logic [31:0] d);
    int idx;
    if (undef(a)) return;
    idx = int'(a >> 2);
    if (idx == 0) m[0] = m[0] & (d & 32'h3F);
    else if (idx >= 5 && idx <= 8) m[idx] = d & 32'hFFF;
    else if (idx != 19) m[idx] = d;
  endtask

  task automatic access(input logic [7:0] a, input logic w, input logic r,
                        input logic [31:0] d, input string tag);
    logic [31:0] e;
    logic ee;
    e = r ? exp_rd(a) : 32'h0;
    if (w) exp_wr(a, d);
    ee = (w || r) && undef(a);
    bus_addr = a; bus_wdata = d; bus_we = w; bus_re = r;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    if (r) begin
      chk(tag, bus_rdata, e);
      last_rd = bus_rdata;
    end
    chk("R11 err", {31'h0, bus_err}, {31'h0, ee});
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    access(a, 1'b0, 1'b1, 32'h0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    access(a, 1'b1, 1'b0, d, tag);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 20; i++) m[i] = 32'h0;
    m[9] = 32'h0000_0FFF;
    m_samp = 12'h0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R12 interrupt low
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R12", {31'h0, irq}, 32'h0);
    for (int i = 0; i < 20; i++) rd(8'(i * 4), "R1");

    // R2 hold after read
    rd(8'h24, "R2 read");
    wr(8'h28, 32'h1234_5678, "R5");
    chk("R2 hold", bus_rdata, 32'h0000_0FFF);

    // R3 status cannot be set
    wr(8'h00, 32'hFFFF_FFFF, "R3");
    rd(8'h00, "R3");

    // R4 control-2 top nibble masked
    wr(8'h08, 32'hFFFF_FFFE, "R4");
    rd(8'h08, "R4");
    wr(8'h08, 32'h0, "R4");

    // R5 full-width storage
    wr(8'h04, 32'hA5A5_A5A5, "R5"); rd(8'h04, "R5");
    wr(8'h38, 32'hDEAD_BEEF, "R5"); rd(8'h38, "R5");
    wr(8'h30, 32'h8000_0001, "R5"); rd(8'h30, "R5");

    // R6 offset truncation, R7 subtraction with wrap
    wr(8'h14, 32'hFFFF_1234, "R6"); rd(8'h14, "R6");
    wr(8'h3C, 32'h0000_0010, "R7");
    wr(8'h14, 32'h0000_0020, "R6");
    rd(8'h3C, "R7");
    wr(8'h48, 32'h1000_0000, "R7"); wr(8'h20, 32'hABC, "R6"); rd(8'h48, "R7");

    // R8 no sample without start
    wr(8'h04, 32'h0, "R5");
    wr(8'h08, 32'h0000_0001, "R8");
    rd(8'h4C, "R8 idle");
    wr(8'h08, 32'h4000_0000, "R8");
    rd(8'h4C, "R8 off");
    // R9 first sample is 7, start consumed
    wr(8'h08, 32'h4000_0001, "R8");
    rd(8'h4C, "R9");
    chk("R9 first", last_rd, 32'h7);
    rd(8'h4C, "R8 consumed");
    rd(8'h08, "R8 start cleared");
    chk("R8 ctl2", last_rd, 32'h0000_0001);

    // R9 each resolution, with wrap
    for (int res = 3; res >= 0; res--) begin
      wr(8'h04, 32'(res) << 24, "R9");
      for (int k = 0; k < 12; k++) begin
        wr(8'h08, 32'h4000_0001, "R8");
        rd(8'h4C, "R9");
      end
    end

    // R10 left alignment
    for (int k = 0; k < 6; k++) begin
      wr(8'h08, 32'h4000_0801, "R10");
      rd(8'h4C, "R10");
    end

    // R11 unmapped offsets and ignored data write
    rd(8'h50, "R11");
    wr(8'h51, 32'hFFFF_FFFF, "R11");
    rd(8'h06, "R11");
    wr(8'h4C, 32'h0000_0FFF, "R11");
    wr(8'h08, 32'h4000_0001, "R8");
    rd(8'h4C, "R11 data write ignored");
    rd(8'h04, "R11");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic w, r;
      if ($urandom % 8 == 0) a = 8'($urandom % 96);
      else a = 8'(($urandom % 20) * 4);
      w = 1'($urandom % 2);
      r = w ? ($urandom % 4 == 0) : 1'b1;
      d = $urandom;
      if (a == 8'h08 && ($urandom % 2 == 1)) d = d | 32'h4000_0001;
      if (a == 8'h04 && ($urandom % 2 == 1)) d = d & 32'h0300_0000;
      access(a, w, r, d, tag_of(a));
      chk("R12", {31'h0, irq}, 32'h0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule